// File: doc/BRIEF.md
# Indirect PCIe Configuration Access Window

This block lets a CPU reach the configuration space of any PCIe function through a single 4 KB window. Software first writes the bus number and the device/function number of the function it wants into a target register. After that, every CPU read or write that lands inside the window becomes one configuration request for that function. The offset inside the window is the configuration register offset. To reach another function, software rewrites the target register. There is no flat enhanced-configuration map.

The CPU side is a simple memory-mapped slave with a request/acknowledge handshake. The link side is a request/response master. A request carries the write flag, the Type 0/Type 1 selection, bus, device/function, dword-aligned register offset, byte enables and write data. A completion returns data and an Unsupported Request flag. Only one configuration request is in flight at a time. The CPU access stays stalled until its completion has arrived.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset, the target register and the root bus register read as zero, `cpu_ack` is low and no configuration request is pending.
- R2: The target register sits at byte address 0x140. Bits 7:0 hold the device/function number and bits 15:8 hold the bus number. Each byte is updated only when its byte enable is set, and the register reads back what was written.
- R3: Bits 31:16 of the target register always read as zero, and writes to them have no effect.
- R4: A root bus register at byte address 0x144 holds a bus number in bits 7:0. It updates only when byte enable 0 is set and reads back what was written.
- R5: A CPU access to byte addresses 0x1000 through 0x1FFF issues exactly one configuration request. Its bus and device/function come from the target register. Its offset is (address − 0x1000) with bits 1:0 cleared. Its byte enables and write data are those of the CPU, and `cfg_req_write` equals the CPU write flag.
- R6: `cfg_req_type1` is 0 when the target bus equals the root bus register, and 1 otherwise.
- R7: A window access is acknowledged exactly one cycle after its completion is accepted, and never earlier. Read data is the completion data; a window write returns zero.
- R8: A window read whose completion carries the Unsupported Request flag returns 0xFFFFFFFF.
- R9: While `cfg_req_valid` is high and `cfg_req_ready` is low, the request stays valid and all its fields stay stable. A completion that arrives while no request is outstanding is ignored.
- R10: A target register write takes effect for the next window access. A request keeps the target it was issued with.
- R11: A CPU access outside the two registers and the window is acknowledged one cycle later. A read returns zero, a write changes nothing, and no configuration request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | Byte address in controller space |
| cpu_be | input | 4 | Byte enables |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-cycle access completion |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Link layer accepts request |
| cfg_req_write | output | 1 | Configuration write |
| cfg_req_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_off | output | 12 | Dword-aligned register byte offset |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_data | output | 32 | Write data |
| cfg_cpl_valid | input | 1 | Completion valid |
| cfg_cpl_ur | input | 1 | Completion is Unsupported Request |
| cfg_cpl_data | input | 32 | Completion data |

## Verification
The hardest situation to reach from the ports is a request that the link layer holds off. The CPU is stalled through that time, and a stray completion can reach the block while nothing is outstanding. The stimulus runs the link responder in parallel with each CPU access. It programs a delay before `cfg_req_ready` and another before the completion, and checks stability of the request fields and absence of `cpu_ack` on every cycle of those gaps. A separate step pulses `cfg_cpl_valid` while idle and then reads the registers through the CPU port to show nothing moved.

// File: rtl/cfgwin_pkg.sv
// Shared types for the configuration access window.
// Assumes: used by every module of cfgwin_bridge.
package cfgwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } cfg_state_e;

    typedef enum logic [1:0] {
        SP_NONE   = 2'd0,
        SP_TARGET = 2'd1,
        SP_ROOT   = 2'd2,
        SP_WINDOW = 2'd3
    } space_e;
endpackage

// File: rtl/cfgwin_decode.sv
// Address decoder: classifies a CPU byte address as the target register,
// the root bus register, the configuration window, or unmapped space.
// Assumes: register offsets are word aligned; the window lies inside the
// address range.
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int TGT_OFF   = 'h140,
    parameter int ROOT_OFF  = 'h144,
    parameter int WIN_BASE  = 'h1000,
    parameter int WIN_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output space_e            space
);
    localparam int unsigned WIN_END = WIN_BASE + WIN_BYTES;

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr);

    // Compare the address against each mapped region.
    always_comb begin
        space = SP_NONE;
        if (addr_ext >= 32'(WIN_BASE) && addr_ext < WIN_END)
            space = SP_WINDOW;
        else if (addr_ext[31:2] == 30'(TGT_OFF / 4))
            space = SP_TARGET;
        else if (addr_ext[31:2] == 30'(ROOT_OFF / 4))
            space = SP_ROOT;
    end
endmodule

// File: rtl/cfgwin_target_regs.sv
// Holds the configuration target (bus, device/function) and the root bus
// number. Each byte is written only under its byte enable.
// Assumes: write strobes are single-cycle pulses from the access FSM.
module cfgwin_target_regs #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_tgt,
    input  logic               wr_root,
    input  logic [1:0]         be,
    input  logic [15:0]        wdata,
    output logic [BUS_W-1:0]   tgt_bus,
    output logic [DEVFN_W-1:0] tgt_devfn,
    output logic [BUS_W-1:0]   root_bus
);
    // Target register update, byte enable per field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_bus   <= '0;
            tgt_devfn <= '0;
        end else if (wr_tgt) begin
            if (be[0]) tgt_devfn <= wdata[DEVFN_W-1:0];
            if (be[1]) tgt_bus   <= wdata[8 +: BUS_W];
        end
    end

    // Root bus register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            root_bus <= '0;
        else if (wr_root && be[0])
            root_bus <= wdata[BUS_W-1:0];
    end

    // R2: devfn takes the written byte.
    a_r2_devfn_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tgt && be[0]) |=> tgt_devfn == $past(wdata[DEVFN_W-1:0]));

    // R2: bus field untouched when its byte enable is clear.
    a_r2_bus_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tgt && !be[1]) |=> $stable(tgt_bus));

    // R4: root bus changes only through its own write strobe.
    a_r4_root_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_root |=> $stable(root_bus));
endmodule

// File: rtl/cfgwin_req_fsm.sv
// Access sequencer: serves register accesses in one cycle and converts
// window accesses into one configuration request, waiting for its
// completion before acknowledging the CPU.
// Assumes: the CPU holds cpu_req until cpu_ack and drops it afterwards.
module cfgwin_req_fsm
    import cfgwin_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int DATA_W  = 32,
    parameter int BE_W    = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  space_e             space,
    input  logic [OFF_W-1:0]   win_off,
    input  logic [BE_W-1:0]    cpu_be,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic [DATA_W-1:0]  reg_rdata,
    input  logic [BUS_W-1:0]   tgt_bus,
    input  logic [DEVFN_W-1:0] tgt_devfn,
    input  logic [BUS_W-1:0]   root_bus,
    output logic               wr_tgt,
    output logic               wr_root,
    output logic               cpu_ack,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cfg_req_valid,
    input  logic               cfg_req_ready,
    output logic               cfg_req_write,
    output logic               cfg_req_type1,
    output logic [BUS_W-1:0]   cfg_req_bus,
    output logic [DEVFN_W-1:0] cfg_req_devfn,
    output logic [OFF_W-1:0]   cfg_req_off,
    output logic [BE_W-1:0]    cfg_req_be,
    output logic [DATA_W-1:0]  cfg_req_data,
    input  logic               cfg_cpl_valid,
    input  logic               cfg_cpl_ur,
    input  logic [DATA_W-1:0]  cfg_cpl_data
);
    cfg_state_e state;
    logic       start;

    // A new CPU access is taken only in the idle state.
    assign start   = (state == ST_IDLE) && cpu_req;
    assign wr_tgt  = start && cpu_we && (space == SP_TARGET);
    assign wr_root = start && cpu_we && (space == SP_ROOT);

    assign cfg_req_valid = (state == ST_ISSUE);
    assign cpu_ack       = (state == ST_DONE);

    // Sequence state, request capture and read data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cpu_rdata     <= '0;
            cfg_req_write <= 1'b0;
            cfg_req_type1 <= 1'b0;
            cfg_req_bus   <= '0;
            cfg_req_devfn <= '0;
            cfg_req_off   <= '0;
            cfg_req_be    <= '0;
            cfg_req_data  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        if (space == SP_WINDOW) begin
                            cfg_req_write <= cpu_we;
                            cfg_req_type1 <= (tgt_bus != root_bus);
                            cfg_req_bus   <= tgt_bus;
                            cfg_req_devfn <= tgt_devfn;
                            cfg_req_off   <= {win_off[OFF_W-1:2], 2'b00};
                            cfg_req_be    <= cpu_be;
                            cfg_req_data  <= cpu_wdata;
                            state         <= ST_ISSUE;
                        end else begin
                            cpu_rdata <= cpu_we ? '0 : reg_rdata;
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (cfg_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cfg_cpl_valid) begin
                        if (cfg_req_write)   cpu_rdata <= '0;
                        else if (cfg_cpl_ur) cpu_rdata <= '1;
                        else                 cpu_rdata <= cfg_cpl_data;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a held-off request keeps its fields.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && !cfg_req_ready) |=>
            (cfg_req_valid && $stable(cfg_req_off) && $stable(cfg_req_bus) &&
             $stable(cfg_req_devfn) && $stable(cfg_req_be) &&
             $stable(cfg_req_data) && $stable(cfg_req_write)));

    // R6: issued type matches the live root bus comparison.
    a_r6_type_sel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_type1 == (cfg_req_bus != root_bus)));

    // R8: unsupported-request read returns all ones on the next cycle.
    a_r8_ur_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && cfg_cpl_valid && cfg_cpl_ur && !cfg_req_write)
            |=> (cpu_ack && cpu_rdata == '1));

    // R7: acknowledge is a single-cycle pulse.
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R11: register or unmapped accesses never raise a request.
    a_r11_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (start && space != SP_WINDOW) |=> (!cfg_req_valid && cpu_ack));
endmodule

// File: rtl/cfgwin_bridge.sv
// Top level: maps CPU accesses onto the target/root registers and the
// shared 4 KB configuration window, and drives one configuration request
// at a time toward the link layer.
// Assumes: single CPU master following the req/ack handshake.
module cfgwin_bridge
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int TGT_OFF   = 'h140,
    parameter int ROOT_OFF  = 'h144,
    parameter int WIN_BASE  = 'h1000,
    parameter int WIN_BYTES = 4096,
    parameter int BUS_W     = 8,
    parameter int DEVFN_W   = 8,
    parameter int DATA_W    = 32,
    parameter int BE_W      = DATA_W / 8,
    parameter int OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [BE_W-1:0]    cpu_be,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ack,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cfg_req_valid,
    input  logic               cfg_req_ready,
    output logic               cfg_req_write,
    output logic               cfg_req_type1,
    output logic [BUS_W-1:0]   cfg_req_bus,
    output logic [DEVFN_W-1:0] cfg_req_devfn,
    output logic [OFF_W-1:0]   cfg_req_off,
    output logic [BE_W-1:0]    cfg_req_be,
    output logic [DATA_W-1:0]  cfg_req_data,
    input  logic               cfg_cpl_valid,
    input  logic               cfg_cpl_ur,
    input  logic [DATA_W-1:0]  cfg_cpl_data
);
    space_e             space;
    logic               wr_tgt, wr_root;
    logic [BUS_W-1:0]   tgt_bus, root_bus;
    logic [DEVFN_W-1:0] tgt_devfn;
    logic [ADDR_W-1:0]  win_rel;
    logic [DATA_W-1:0]  reg_rdata;

    cfgwin_decode #(
        .ADDR_W(ADDR_W), .TGT_OFF(TGT_OFF), .ROOT_OFF(ROOT_OFF),
        .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_decode (
        .addr (cpu_addr),
        .space(space)
    );

    cfgwin_target_regs #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_tgt   (wr_tgt),
        .wr_root  (wr_root),
        .be       (cpu_be[1:0]),
        .wdata    (cpu_wdata[15:0]),
        .tgt_bus  (tgt_bus),
        .tgt_devfn(tgt_devfn),
        .root_bus (root_bus)
    );

    // Offset of the access inside the window.
    assign win_rel = cpu_addr - ADDR_W'(WIN_BASE);

    // Register read mux; upper target bits read as zero.
    always_comb begin
        reg_rdata = '0;
        if (space == SP_TARGET)
            reg_rdata[8 + BUS_W - 1:0] = {tgt_bus, tgt_devfn};
        else if (space == SP_ROOT)
            reg_rdata[BUS_W-1:0] = root_bus;
    end

    cfgwin_req_fsm #(
        .OFF_W(OFF_W), .BUS_W(BUS_W), .DEVFN_W(DEVFN_W),
        .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .space        (space),
        .win_off      (win_rel[OFF_W-1:0]),
        .cpu_be       (cpu_be),
        .cpu_wdata    (cpu_wdata),
        .reg_rdata    (reg_rdata),
        .tgt_bus      (tgt_bus),
        .tgt_devfn    (tgt_devfn),
        .root_bus     (root_bus),
        .wr_tgt       (wr_tgt),
        .wr_root      (wr_root),
        .cpu_ack      (cpu_ack),
        .cpu_rdata    (cpu_rdata),
        .cfg_req_valid(cfg_req_valid),
        .cfg_req_ready(cfg_req_ready),
        .cfg_req_write(cfg_req_write),
        .cfg_req_type1(cfg_req_type1),
        .cfg_req_bus  (cfg_req_bus),
        .cfg_req_devfn(cfg_req_devfn),
        .cfg_req_off  (cfg_req_off),
        .cfg_req_be   (cfg_req_be),
        .cfg_req_data (cfg_req_data),
        .cfg_cpl_valid(cfg_cpl_valid),
        .cfg_cpl_ur   (cfg_cpl_ur),
        .cfg_cpl_data (cfg_cpl_data)
    );

    // R3: a read of the target register never shows upper bits.
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (space == SP_TARGET) |-> (reg_rdata[DATA_W-1:16] == '0));

    // R5: request target equals the target register while issuing.
    a_r5_target_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_bus == tgt_bus && cfg_req_devfn == tgt_devfn));
endmodule

// File: tb/cfgwin_bridge_bench.sv
// Bench for cfgwin_bridge: behavioural model of the registers, a link
// responder with programmable delays, and a per-clock monitor.
module cfgwin_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        cfg_req_valid, cfg_req_write, cfg_req_type1;
    logic        cfg_req_ready = 1'b0;
    logic [7:0]  cfg_req_bus, cfg_req_devfn;
    logic [11:0] cfg_req_off;
    logic [3:0]  cfg_req_be;
    logic [31:0] cfg_req_data;
    logic        cfg_cpl_valid = 1'b0, cfg_cpl_ur = 1'b0;
    logic [31:0] cfg_cpl_data = '0;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    int cyc = 0;
    logic exp_busy = 1'b0;

    // Behavioural model of the software-visible state.
    logic [7:0] m_bus = 0, m_devfn = 0, m_root = 0;

    always #10 clk = ~clk;

    cfgwin_bridge u_cfgwin_bridge (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock monitor: no request unless a window access is in progress,
    // and acknowledge never two cycles in a row.
    initial begin
        logic prev_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                mon_checks++;
                if (cfg_req_valid && !exp_busy) begin
                    mon_fails++;
                    $display("FAIL R11 actual=req_valid=1 expected=0 at cycle %0d", cyc);
                end
                if (prev_ack && cpu_ack) begin
                    mon_fails++;
                    $display("FAIL R7 actual=ack twice expected=single pulse at cycle %0d", cyc);
                end
            end
            prev_ack = cpu_ack;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Register or unmapped access; acknowledge expected one cycle later.
    task automatic reg_access(input string req, input logic we, input logic [12:0] addr,
                              input logic [31:0] wd, input logic [3:0] be,
                              output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
        do begin @(negedge clk); n++; end while (!cpu_ack && n < 100);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        chk(req, 32'(n), 32'd1);
    endtask

    // Window access with a concurrent link responder.
    task automatic win_access(input string req, input logic we, input logic [12:0] addr,
                              input logic [31:0] wd, input logic [3:0] be,
                              input int rdy_dly, input int cpl_dly,
                              input logic ur, input logic [31:0] cdata);
        int cpl_cyc = -10, ack_cyc = -20;
        logic [31:0] rd = '0;
        logic [31:0] exp_rd;
        exp_rd = we ? 32'h0 : (ur ? 32'hFFFF_FFFF : cdata);
        exp_busy = 1'b1;
        fork
            begin
                int n = 0;
                @(negedge clk);
                cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
                do begin @(negedge clk); n++; end while (!cpu_ack && n < 200);
                ack_cyc = cyc; rd = cpu_rdata;
                cpu_req = 1'b0;
            end
            begin
                int n = 0;
                do begin @(negedge clk); n++; end while (!cfg_req_valid && n < 50);
                chk({req, " R5 req seen"}, 32'(cfg_req_valid), 32'd1);
                if (cfg_req_valid) begin
                    logic [11:0] off0;
                    off0 = cfg_req_off;
                    chk("R5 bus", 32'(cfg_req_bus), 32'(m_bus));
                    chk("R5 devfn", 32'(cfg_req_devfn), 32'(m_devfn));
                    chk("R5 offset", 32'(cfg_req_off), 32'({addr[11:2], 2'b00}));
                    chk("R5 be", 32'(cfg_req_be), 32'(be));
                    chk("R5 write", 32'(cfg_req_write), 32'(we));
                    if (we) chk("R5 data", cfg_req_data, wd);
                    chk("R6 type", 32'(cfg_req_type1), 32'(m_bus != m_root));
                    for (int i = 0; i < rdy_dly; i++) begin
                        @(negedge clk);
                        chk("R9 held valid", 32'(cfg_req_valid), 32'd1);
                        chk("R9 held offset", 32'(cfg_req_off), 32'(off0));
                        chk("R7 no early ack", 32'(cpu_ack), 32'd0);
                    end
                    cfg_req_ready = 1'b1;
                    @(negedge clk);
                    cfg_req_ready = 1'b0;
                    for (int i = 0; i < cpl_dly; i++) begin
                        chk("R7 no ack before completion", 32'(cpu_ack), 32'd0);
                        @(negedge clk);
                    end
                    chk("R7 no ack before completion", 32'(cpu_ack), 32'd0);
                    cfg_cpl_valid = 1'b1; cfg_cpl_ur = ur; cfg_cpl_data = cdata;
                    cpl_cyc = cyc;
                    @(negedge clk);
                    cfg_cpl_valid = 1'b0; cfg_cpl_ur = 1'b0;
                end
            end
        join
        exp_busy = 1'b0;
        chk({req, " R7 ack timing"}, 32'(ack_cyc - cpl_cyc), 32'd1);
        chk({req, " read data"}, rd, exp_rd);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ack", 32'(cpu_ack), 32'd0);
        chk("R1 req_valid", 32'(cfg_req_valid), 32'd0);
        reg_access("R1 timing", 1'b0, 13'h140, 0, 4'hF, rd); chk("R1 target", rd, 32'h0);
        reg_access("R1 timing", 1'b0, 13'h144, 0, 4'hF, rd); chk("R1 root", rd, 32'h0);

        // R2/R3: full write, upper half discarded
        reg_access("R2 timing", 1'b1, 13'h140, 32'hABCD_0312, 4'hF, rd);
        m_bus = 8'h03; m_devfn = 8'h12;
        reg_access("R2 timing", 1'b0, 13'h140, 0, 4'hF, rd);
        chk("R3 upper zero / R2 readback", rd, {16'h0, m_bus, m_devfn});
        // R2: only byte 0 enabled
        reg_access("R2 timing", 1'b1, 13'h140, 32'h0000_FF45, 4'b0001, rd);
        m_devfn = 8'h45;
        reg_access("R2 timing", 1'b0, 13'h140, 0, 4'hF, rd);
        chk("R2 byte enable", rd, {16'h0, m_bus, m_devfn});

        // R5/R6/R7: window read, Type 1, no delays
        win_access("R5 read", 1'b0, 13'h1010, 0, 4'hF, 0, 0, 1'b0, 32'h1122_3344);

        // R4: root bus = 3 then Type 0 write with delays
        reg_access("R4 timing", 1'b1, 13'h144, 32'hFFFF_FF03, 4'b0001, rd);
        m_root = 8'h03;
        reg_access("R4 timing", 1'b0, 13'h144, 0, 4'hF, rd);
        chk("R4 root readback", rd, 32'h0000_0003);
        win_access("R6 write type0", 1'b1, 13'h1FFE, 32'hCAFE_F00D, 4'b0011, 2, 3, 1'b0, 32'h5555_5555);

        // R8: unsupported-request read and write
        win_access("R8 read", 1'b0, 13'h1100, 0, 4'hF, 1, 2, 1'b1, 32'h1234_5678);
        win_access("R8 write", 1'b1, 13'h1104, 32'h0BAD_0BAD, 4'hF, 0, 1, 1'b1, 32'h0);

        // R10: new target applies to the next access
        reg_access("R10 timing", 1'b1, 13'h140, 32'h0000_0710, 4'b0011, rd);
        m_bus = 8'h07; m_devfn = 8'h10;
        win_access("R10 read", 1'b0, 13'h1ABC, 0, 4'b1000, 3, 0, 1'b0, 32'h8765_4321);

        // R11: unmapped write/read, below window edge
        reg_access("R11 timing", 1'b1, 13'h0200, 32'hFFFF_FFFF, 4'hF, rd);
        reg_access("R11 timing", 1'b0, 13'h0200, 0, 4'hF, rd); chk("R11 unmapped read", rd, 32'h0);
        reg_access("R11 timing", 1'b0, 13'h0FFC, 0, 4'hF, rd); chk("R11 edge read", rd, 32'h0);
        reg_access("R11 timing", 1'b0, 13'h140, 0, 4'hF, rd);
        chk("R11 target untouched", rd, {16'h0, m_bus, m_devfn});

        // R9: stray completion while idle
        @(negedge clk);
        cfg_cpl_valid = 1'b1; cfg_cpl_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cfg_cpl_valid = 1'b0;
        chk("R9 stray ack", 32'(cpu_ack), 32'd0);
        @(negedge clk);
        chk("R9 stray ack later", 32'(cpu_ack), 32'd0);
        reg_access("R9 timing", 1'b0, 13'h144, 0, 4'hF, rd);
        chk("R9 state kept", rd, 32'(m_root));
        win_access("R9 after stray", 1'b0, 13'h1000, 0, 4'hF, 1, 1, 1'b0, 32'h0F0F_0F0F);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(20 * 150000);
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end
endmodule